// File: doc/BRIEF.md
# Privileged Register Move Decoder

This block decodes the four two-byte-opcode instructions that copy a value between a general-purpose register (GPR) and either a control register (CR) or a debug register (DR). It takes the second opcode byte, the ModRM byte, the REX.R and REX.B extension bits and the LOCK prefix flag. It also takes a feature enable that lets LOCK select CR8, a 64-bit-mode flag and the current privilege level.

From these it works out the transfer direction, the register class, both register indices, the operand width, whether the source must be zero-extended, a virtualization intercept code, whether the access touches the task-priority register (CR8), and whether the current translation block must end. It also raises an invalid-opcode or privilege fault where one applies. The register access itself, the aliasing rules for DR4/DR5 and the handling of intercepts are left to later stages.

The block has a strobe-in, strobe-out interface and no back-pressure. A one-cycle pulse on `dec_valid` captures the inputs. One cycle later every result is presented together with a one-cycle `out_valid` pulse. The results then stay unchanged until the next strobe, so a consumer may sample them at any time after the pulse. Strobes may come on back-to-back cycles.

Top module: `sreg_move_decoder`

## Requirements
- R1: Only opcodes 0x20 to 0x23 are accepted. Opcode bit 1 selects a write to the special register (`is_write`=1), and opcode bit 0 selects the debug class (`is_debug`=1). So 0x20 reads a CR, 0x21 reads a DR, 0x22 writes a CR and 0x23 writes a DR. Any other opcode raises `fault_ud`.
- R2: ModRM bits [7:6] are ignored. Every result is the same whatever value those two bits hold.
- R3: `sreg_idx` = {rex_r, modrm[5:3]} and `gpr_idx` = {rex_b, modrm[2:0]}.
- R4: CR index 0 becomes 8 when `lock_pfx` and `cr8_alias_en` are both 1, and `lock_used` is then 1. In every other case `lock_used` is 0, and the DR class never remaps.
- R5: For the CR class, only the final indices 0, 2, 3, 4 and 8 are legal. Any other index raises `fault_ud`.
- R6: For the DR class, an index of 8 or more raises `fault_ud`. Indices 0 to 7, including 4 and 5, are accepted.
- R7: `op_64bit` equals `long_mode`. The operand is 64 bits in 64-bit mode and 32 bits otherwise, and there is no 16-bit form.
- R8: A privilege level other than 0 raises `fault_gp`. When `fault_ud` is raised, `fault_gp` stays 0.
- R9: `icpt_code` is the class base plus the final index. The bases are: read CR 0x00, write CR 0x10, read DR 0x20, write DR 0x30. `icpt_code` is 0 when `fault_ud` is raised.
- R10: A write with no fault sets both `zero_ext` and `end_block`. A read, or any faulting decode, leaves both at 0.
- R11: `io_access` is 1 exactly when the CR class is used with final index 8 and there is no fault.
- R12: `out_valid` pulses one cycle after `dec_valid`. Results change only on a strobe. After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | Decode strobe |
| opcode | input | 8 | Second opcode byte |
| modrm | input | 8 | ModRM byte |
| rex_r | input | 1 | REX.R extension bit |
| rex_b | input | 1 | REX.B extension bit |
| lock_pfx | input | 1 | LOCK prefix present |
| cr8_alias_en | input | 1 | Allows LOCK to redirect CR0 to CR8 |
| long_mode | input | 1 | 64-bit mode |
| cpl | input | 2 | Current privilege level |
| out_valid | output | 1 | Results-ready pulse |
| is_write | output | 1 | 1 = GPR to special register |
| is_debug | output | 1 | 1 = debug class, 0 = control class |
| sreg_idx | output | 4 | Final special-register index |
| gpr_idx | output | 4 | GPR index |
| op_64bit | output | 1 | 64-bit operand width |
| zero_ext | output | 1 | Zero-extend the source |
| icpt_code | output | 8 | Intercept code |
| io_access | output | 1 | Access to CR8 |
| end_block | output | 1 | End the translation block |
| lock_used | output | 1 | LOCK consumed by the CR8 remap |
| fault_ud | output | 1 | Invalid opcode |
| fault_gp | output | 1 | Privilege fault |

## Verification
Every result is due exactly one rising edge after the strobe that carries its inputs. The bench drives each strobe on a falling edge and samples on the following falling edge, where `out_valid` and all fields must appear together. It then drops the strobe and checks, one cycle later, that `out_valid` has fallen while the fields are still held. The vector table covers each class, the remap, the legality limits and fault priority. Directed tests sweep the ignored ModRM bits and check the state after reset.

// File: rtl/sreg_move_pkg.sv
package sreg_move_pkg;
  localparam int IDX_W  = 4;
  localparam int ICPT_W = 8;
  localparam int GPR_W  = 4;

  typedef enum logic [1:0] {
    XFER_RD_CR = 2'b00,
    XFER_RD_DR = 2'b01,
    XFER_WR_CR = 2'b10,
    XFER_WR_DR = 2'b11
  } xfer_e;

  typedef struct packed {
    logic              is_write;
    logic              is_debug;
    logic [IDX_W-1:0]  sreg_idx;
    logic [GPR_W-1:0]  gpr_idx;
    logic              op_64bit;
    logic              zero_ext;
    logic [ICPT_W-1:0] icpt_code;
    logic              io_access;
    logic              end_block;
    logic              lock_used;
    logic              fault_ud;
    logic              fault_gp;
  } dec_res_t;
endpackage

// File: rtl/sreg_idx_unit.sv
module sreg_idx_unit #(
  parameter int          IDX_W         = 4,
  parameter logic [15:0] CR_LEGAL_MASK = 16'h011D,
  parameter int          DR_COUNT      = 8,
  parameter int          ALIAS_IDX     = 8
) (
  input  logic             is_debug,
  input  logic             rex_r,
  input  logic [2:0]       reg_field,
  input  logic             lock_pfx,
  input  logic             alias_en,
  output logic [IDX_W-1:0] idx,
  output logic             lock_used,
  output logic             idx_bad
);
  localparam int NIDX = 1 << IDX_W;

  logic [IDX_W-1:0] raw_idx;
  logic             remap;
  logic [NIDX-1:0]  legal_vec;

  assign raw_idx   = {rex_r, reg_field};
  assign remap     = !is_debug && lock_pfx && alias_en && (raw_idx == '0);
  assign idx       = remap ? IDX_W'(ALIAS_IDX) : raw_idx;
  assign lock_used = remap;

  for (genvar i = 0; i < NIDX; i++) begin : g_legal
    localparam logic CR_OK = CR_LEGAL_MASK[i];
    localparam logic DR_OK = (i < DR_COUNT);
    assign legal_vec[i] = is_debug ? DR_OK : CR_OK;
  end

  assign idx_bad = !legal_vec[idx];
endmodule

// File: rtl/sreg_attr_unit.sv
module sreg_attr_unit
  import sreg_move_pkg::*;
#(
  parameter int                IDX_W      = 4,
  parameter int                ICPT_W     = 8,
  parameter logic [ICPT_W-1:0] BASE_RD_CR = 8'h00,
  parameter logic [ICPT_W-1:0] BASE_WR_CR = 8'h10,
  parameter logic [ICPT_W-1:0] BASE_RD_DR = 8'h20,
  parameter logic [ICPT_W-1:0] BASE_WR_DR = 8'h30,
  parameter int                IO_IDX     = 8
) (
  input  xfer_e             kind,
  input  logic [IDX_W-1:0]  idx,
  input  logic              fault_ud,
  input  logic              fault_gp,
  output logic [ICPT_W-1:0] icpt_code,
  output logic              zero_ext,
  output logic              end_block,
  output logic              io_access
);
  logic [ICPT_W-1:0] base;
  logic              clean;

  always_comb begin
    unique case (kind)
      XFER_RD_CR: base = BASE_RD_CR;
      XFER_WR_CR: base = BASE_WR_CR;
      XFER_RD_DR: base = BASE_RD_DR;
      default:    base = BASE_WR_DR;
    endcase
  end

  assign clean     = !fault_ud && !fault_gp;
  assign icpt_code = fault_ud ? '0 : base + ICPT_W'(idx);
  assign zero_ext  = clean && kind[1];
  assign end_block = clean && kind[1];
  assign io_access = clean && !kind[0] && (idx == IDX_W'(IO_IDX));
endmodule

// File: rtl/sreg_move_decoder.sv
module sreg_move_decoder
  import sreg_move_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dec_valid,
  input  logic [7:0]        opcode,
  input  logic [7:0]        modrm,
  input  logic              rex_r,
  input  logic              rex_b,
  input  logic              lock_pfx,
  input  logic              cr8_alias_en,
  input  logic              long_mode,
  input  logic [1:0]        cpl,
  output logic              out_valid,
  output logic              is_write,
  output logic              is_debug,
  output logic [IDX_W-1:0]  sreg_idx,
  output logic [GPR_W-1:0]  gpr_idx,
  output logic              op_64bit,
  output logic              zero_ext,
  output logic [ICPT_W-1:0] icpt_code,
  output logic              io_access,
  output logic              end_block,
  output logic              lock_used,
  output logic              fault_ud,
  output logic              fault_gp
);
  localparam logic [5:0] OPC_HI = 6'b001000;

  logic             op_ok;
  xfer_e            kind;
  logic [IDX_W-1:0] idx_n;
  logic             lock_used_n, idx_bad;
  logic             ud_n, gp_n;
  logic [ICPT_W-1:0] icpt_n;
  logic             zext_n, eob_n, io_n;
  logic             unused_mod;
  dec_res_t         res_n, res_q;
  logic             vld_q;

  assign unused_mod = ^modrm[7:6];
  assign op_ok      = (opcode[7:2] == OPC_HI);
  assign kind       = xfer_e'(opcode[1:0]);

  sreg_idx_unit #(.IDX_W(IDX_W)) u_idx (
    .is_debug (opcode[0]),
    .rex_r    (rex_r),
    .reg_field(modrm[5:3]),
    .lock_pfx (lock_pfx),
    .alias_en (cr8_alias_en),
    .idx      (idx_n),
    .lock_used(lock_used_n),
    .idx_bad  (idx_bad)
  );

  assign ud_n = !op_ok || idx_bad;
  assign gp_n = !ud_n && (cpl != 2'd0);

  sreg_attr_unit #(.IDX_W(IDX_W), .ICPT_W(ICPT_W)) u_attr (
    .kind     (kind),
    .idx      (idx_n),
    .fault_ud (ud_n),
    .fault_gp (gp_n),
    .icpt_code(icpt_n),
    .zero_ext (zext_n),
    .end_block(eob_n),
    .io_access(io_n)
  );

  always_comb begin
    res_n.is_write  = opcode[1];
    res_n.is_debug  = opcode[0];
    res_n.sreg_idx  = idx_n;
    res_n.gpr_idx   = {rex_b, modrm[2:0]};
    res_n.op_64bit  = long_mode;
    res_n.zero_ext  = zext_n;
    res_n.icpt_code = icpt_n;
    res_n.io_access = io_n;
    res_n.end_block = eob_n;
    res_n.lock_used = lock_used_n && !ud_n;
    res_n.fault_ud  = ud_n;
    res_n.fault_gp  = gp_n;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
    end else begin
      vld_q <= dec_valid;
      if (dec_valid) res_q <= res_n;
    end
  end

  assign out_valid = vld_q;
  assign is_write  = res_q.is_write;
  assign is_debug  = res_q.is_debug;
  assign sreg_idx  = res_q.sreg_idx;
  assign gpr_idx   = res_q.gpr_idx;
  assign op_64bit  = res_q.op_64bit;
  assign zero_ext  = res_q.zero_ext;
  assign icpt_code = res_q.icpt_code;
  assign io_access = res_q.io_access;
  assign end_block = res_q.end_block;
  assign lock_used = res_q.lock_used;
  assign fault_ud  = res_q.fault_ud;
  assign fault_gp  = res_q.fault_gp;

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |=> out_valid); // R12
  AST_HOLD_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |=> $stable(sreg_idx) && $stable(icpt_code) && $stable(fault_ud)); // R12
  AST_PRIV_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && (cpl != 2'd0) |=> fault_ud || fault_gp); // R8
  AST_UD_OVER_GP: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && fault_ud |-> !fault_gp); // R8
  AST_CR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !fault_ud && !is_debug |-> sreg_idx inside {4'd0, 4'd2, 4'd3, 4'd4, 4'd8}); // R5
  AST_DR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !fault_ud && is_debug |-> sreg_idx < 4'd8); // R6
  AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (fault_ud || fault_gp) |-> !end_block && !zero_ext && !io_access); // R10
  AST_CR8_REMAP: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && (opcode inside {8'h20, 8'h22}) && lock_pfx && cr8_alias_en
      && !rex_r && (modrm[5:3] == 3'd0) |=> (sreg_idx == 4'd8) && lock_used); // R4
endmodule

// File: tb/sreg_move_decoder_tb.sv
`timescale 1ns/1ps
module sreg_move_decoder_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic       dec_valid = 0;
  logic [7:0] opcode = 0, modrm = 0;
  logic       rex_r = 0, rex_b = 0, lock_pfx = 0, cr8_alias_en = 0, long_mode = 0;
  logic [1:0] cpl = 0;
  logic       out_valid, is_write, is_debug, op_64bit, zero_ext, io_access;
  logic       end_block, lock_used, fault_ud, fault_gp;
  logic [3:0] sreg_idx, gpr_idx;
  logic [7:0] icpt_code;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  sreg_move_decoder u_dut (.*);

  typedef struct packed {
    logic [7:0] op;
    logic [7:0] mrm;
    logic       rr, rb, lk, al, lm;
    logic [1:0] pl;
    logic       ud, gp;
    logic [3:0] sidx;
    logic [7:0] icpt;
    logic       io, eob, lu;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{8'h20, 8'hC3, 0,0,0,0,0, 2'd0, 0,0, 4'd0,  8'h00, 0,0,0},
    '{8'h22, 8'h1A, 0,0,0,0,0, 2'd0, 0,0, 4'd3,  8'h13, 0,1,0},
    '{8'h20, 8'h05, 0,0,1,1,0, 2'd0, 0,0, 4'd8,  8'h08, 1,0,1},
    '{8'h22, 8'h00, 0,0,1,0,0, 2'd0, 0,0, 4'd0,  8'h10, 0,1,0},
    '{8'h22, 8'h00, 1,0,0,0,1, 2'd0, 0,0, 4'd8,  8'h18, 1,1,0},
    '{8'h20, 8'h08, 0,0,0,0,0, 2'd0, 1,0, 4'd1,  8'h00, 0,0,0},
    '{8'h20, 8'h28, 1,0,0,0,0, 2'd0, 1,0, 4'd13, 8'h00, 0,0,0},
    '{8'h21, 8'hF8, 0,0,0,0,0, 2'd0, 0,0, 4'd7,  8'h27, 0,0,0},
    '{8'h23, 8'h60, 0,0,0,0,0, 2'd0, 0,0, 4'd4,  8'h34, 0,1,0},
    '{8'h21, 8'h00, 1,0,0,0,0, 2'd0, 1,0, 4'd8,  8'h00, 0,0,0},
    '{8'h21, 8'h00, 0,0,1,1,0, 2'd0, 0,0, 4'd0,  8'h20, 0,0,0},
    '{8'h22, 8'hE0, 0,0,0,0,0, 2'd3, 0,1, 4'd4,  8'h14, 0,0,0},
    '{8'h20, 8'h08, 0,0,0,0,0, 2'd3, 1,0, 4'd1,  8'h00, 0,0,0},
    '{8'h24, 8'hC0, 0,0,0,0,0, 2'd0, 1,0, 4'd0,  8'h00, 0,0,0},
    '{8'h23, 8'h15, 0,1,0,0,1, 2'd0, 0,0, 4'd2,  8'h32, 0,1,0}
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic strobe(input vec_t v);
    @(negedge clk);
    opcode = v.op; modrm = v.mrm; rex_r = v.rr; rex_b = v.rb;
    lock_pfx = v.lk; cr8_alias_en = v.al; long_mode = v.lm; cpl = v.pl;
    dec_valid = 1;
    @(negedge clk);
    dec_valid = 0;
  endtask

  task automatic check_vec(input vec_t v, input string tag);
    logic [2:0] kind_w;
    kind_w = {1'b0, v.op[1:0]};
    chk("R12", {tag, " out_valid"}, out_valid, 1);
    chk("R1",  {tag, " is_write"},  is_write, v.op[1]);
    chk("R1",  {tag, " is_debug"},  is_debug, v.op[0]);
    chk("R5/R6 fault_ud", tag, fault_ud, v.ud);
    chk("R8",  {tag, " fault_gp"},  fault_gp, v.gp);
    chk("R3",  {tag, " sreg_idx"},  sreg_idx, v.sidx);
    chk("R3",  {tag, " gpr_idx"},   gpr_idx, {v.rb, v.mrm[2:0]});
    chk("R4",  {tag, " lock_used"}, lock_used, v.lu);
    chk("R7",  {tag, " op_64bit"},  op_64bit, v.lm);
    chk("R9",  {tag, " icpt_code"}, icpt_code, v.icpt);
    chk("R10", {tag, " end_block"}, end_block, v.eob);
    chk("R10", {tag, " zero_ext"},  zero_ext, v.eob);
    chk("R11", {tag, " io_access"}, io_access, v.io);
    if (kind_w > 3) $display("unreachable");
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12", "reset out_valid", out_valid, 0);
    chk("R12", "reset icpt_code", icpt_code, 0);
    chk("R12", "reset sreg_idx", sreg_idx, 0);
    chk("R12", "reset faults", {fault_ud, fault_gp}, 0);
    chk("R12", "reset flags", {end_block, zero_ext, io_access, lock_used}, 0);
    rst_n = 1;

    // vector table: R1 R3 R4 R5 R6 R7 R8 R9 R10 R11
    for (int i = 0; i < NV; i++) begin
      strobe(VECS[i]);
      check_vec(VECS[i], $sformatf("vec%0d", i));
    end

    // R12: no strobe -> valid drops, fields held
    @(negedge clk);
    chk("R12", "valid pulse ends", out_valid, 0);
    chk("R12", "held sreg_idx", sreg_idx, VECS[NV-1].sidx);
    chk("R12", "held icpt_code", icpt_code, VECS[NV-1].icpt);

    // R2: ModRM bits [7:6] swept, write CR3 from r10-ish
    for (int m = 0; m < 4; m++) begin
      vec_t v;
      v = '{8'h22, {m[1:0], 6'b011_010}, 0,0,0,0,1, 2'd0, 0,0, 4'd3, 8'h13, 0,1,0};
      strobe(v);
      check_vec(v, $sformatf("R2 mod%0d", m));
    end

    // R12: back-to-back strobes
    @(negedge clk);
    opcode = 8'h21; modrm = 8'h28; rex_r = 0; rex_b = 0; lock_pfx = 0;
    cr8_alias_en = 0; long_mode = 0; cpl = 0; dec_valid = 1;
    @(negedge clk);
    chk("R12", "b2b first idx", sreg_idx, 4'd5);
    chk("R6",  "DR5 accepted", fault_ud, 0);
    opcode = 8'h20; modrm = 8'h20;
    @(negedge clk);
    dec_valid = 0;
    chk("R12", "b2b second valid", out_valid, 1);
    chk("R5",  "CR4 legal", {fault_ud, sreg_idx}, {1'b0, 4'd4});

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule